// File: doc/BRIEF.md
# Directly Addressed Buffer SPI Flash Command Engine

This block issues single SPI flash commands from a register window. Software writes an opcode byte, a transmit byte count and a receive byte count. It writes the outgoing data into a 71-byte buffer that is mapped straight into the register space, and then sets a start bit. The engine lowers chip select and shifts out the opcode followed by the transmit bytes. It then clocks in the requested number of response bytes and places them in the buffer just after the transmit data. When the command is done it raises chip select again and clears the busy indication.

The serial clock rate comes from a 16-bit speed word that holds four 4-bit rate codes. Only the top field, which selects the normal command rate, drives the clock divider. The divider runs from a reference clock whose frequency is a parameter. A separate enable bit must be set before any command can start. Count values above the usable buffer limit of 68 are saturated, and a sticky flag records that this happened.

Top module: `lbspi_engine`

## Requirements
- R1: After reset, the opcode (0x00), both counts (0x48, 0x4B), the enable bit (0x20 bit 0), the busy bit (0x02 bit 0) and the overflow flag (0x4C bit 0) read 0. The speed word reads 0x3333. Chip select is high and SCK is low.
- R2: The opcode, the enable bit, the speed word and both counts read back the value written. The speed word is little-endian: its low byte is at 0x22 and its high byte at 0x23.
- R3: A count write above 68 stores 68 and sets the overflow flag at 0x4C bit 0. The flag stays set until a write of 1 to that bit clears it.
- R4: Writing 1 to 0x02 bit 0 while the enable bit is 1 starts a command, and bit 0 then reads 1 until the command ends. While the enable bit is 0, the same write starts nothing.
- R5: With chip select held low, one command sends the opcode, then buffer bytes 0 to tx-1, then rx bytes of 0x00, MSB first. That is exactly 8*(1+tx+rx) SCK pulses.
- R6: The bus uses SPI mode 0. SCK idles low while chip select is high, MOSI changes only on falling SCK edges, and MISO is sampled on rising edges.
- R7: Response byte n is stored at buffer index (tx+n) mod 71. Entries that no response byte lands on keep their contents.
- R8: Every SCK half period lasts ceil(REF_KHZ/(2*rate)) reference cycles. The rate comes from the speed word bits 15:12 as follows: code 0 = 66 MHz, 1 = 33 MHz, 2 = 22 MHz, 3 = 16.5 MHz, 4 = 100 MHz, 7 = 800 kHz. Every other code uses 800 kHz. Bits 11:0 have no effect on the rate.
- R9: The busy bit falls exactly 16*(1+tx+rx)*half cycles after the clock edge that samples the start write.
- R10: While a command runs, writes to the opcode, the counts, the speed word, the enable bit and the buffer are ignored.
- R11: Buffer byte i reads and writes at address 0x80+i, for i from 0 to 70.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Register reads are combinational, so the bench sets the address at a falling clock edge and samples one time step later. Every rising SCK edge follows the previous edge by exactly half reference cycles, where the first gap is measured from the falling edge of chip select. The bench timestamps each edge in its flash model and compares the spacing with the half period it derives from the rate table. Busy must clear 16*(1+tx+rx)*half cycles after the edge that samples the start write. The bench counts falling clock edges from the end of that write until busy reads 0 and expects exactly that number. Buffer contents and the captured MOSI bytes are compared only after busy has cleared, against a behavioural buffer model and the response pattern of the flash model.

// File: rtl/lbspi_pkg.sv
package lbspi_pkg;

   localparam logic [7:0] ADR_OPCODE   = 8'h00;
   localparam logic [7:0] ADR_CTRL     = 8'h02;
   localparam logic [7:0] ADR_ENABLE   = 8'h20;
   localparam logic [7:0] ADR_SPEED_LO = 8'h22;
   localparam logic [7:0] ADR_SPEED_HI = 8'h23;
   localparam logic [7:0] ADR_TXCNT    = 8'h48;
   localparam logic [7:0] ADR_RXCNT    = 8'h4B;
   localparam logic [7:0] ADR_STATUS   = 8'h4C;

   localparam logic [15:0] SPEED_RST = 16'h3333;

   // serial rate in kHz for a 4-bit rate code; unknown codes use the slowest rate
   function automatic int unsigned code_rate_khz(input int unsigned code);
      case (code)
         0:       return 66000;
         1:       return 33000;
         2:       return 22000;
         3:       return 16500;
         4:       return 100000;
         default: return 800;
      endcase
   endfunction

   // reference cycles per SCK half period, rounded up
   function automatic int unsigned half_period(input int unsigned ref_khz,
                                               input int unsigned code);
      int unsigned r;
      int unsigned h;
      r = code_rate_khz(code);
      h = (ref_khz + 2 * r - 1) / (2 * r);
      if (h < 1) h = 1;
      return h;
   endfunction

endpackage

// File: rtl/lbspi_clkdiv.sv
module lbspi_clkdiv
   import lbspi_pkg::*;
#(
   parameter int unsigned REF_KHZ = 200000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] code,
   output logic       tick
);
   localparam int unsigned SLOW_HALF = half_period(REF_KHZ, 7);
   localparam int          CW        = $clog2(SLOW_HALF + 1);

   logic [CW-1:0] half_tab [16];
   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   generate
      for (genvar c = 0; c < 16; c++) begin : g_tab
         assign half_tab[c] = CW'(half_period(REF_KHZ, c));
      end
   endgenerate

   assign limit = half_tab[code] - CW'(1);
   assign tick  = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/lbspi_shifter.sv
module lbspi_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       tick,
   input  logic       miso,
   input  logic [7:0] next_data,
   input  logic       next_valid,
   output logic       sck,
   output logic       mosi,
   output logic       cs_n,
   output logic       byte_done,
   output logic [7:0] rx_byte
);
   logic       active;
   logic [7:0] tx_sh;
   logic [2:0] bit_cnt;

   assign cs_n      = ~active;
   assign mosi      = active & tx_sh[7];
   assign byte_done = active && tick && sck && (bit_cnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sck     <= 1'b0;
         tx_sh   <= '0;
         bit_cnt <= '0;
         rx_byte <= '0;
      end else if (start && !active) begin
         active  <= 1'b1;
         sck     <= 1'b0;
         tx_sh   <= next_data;
         bit_cnt <= 3'd7;
      end else if (active && tick) begin
         if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
         end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd0) begin
               if (next_valid) begin
                  tx_sh   <= next_data;
                  bit_cnt <= 3'd7;
               end else begin
                  active <= 1'b0;
               end
            end else begin
               tx_sh   <= {tx_sh[6:0], 1'b0};
               bit_cnt <= bit_cnt - 3'd1;
            end
         end
      end
   end

endmodule

// File: rtl/lbspi_buf.sv
module lbspi_buf #(
   parameter int DEPTH = 71,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [IW-1:0] host_idx,
   input  logic [7:0]    host_wd,
   input  logic          eng_we,
   input  logic [IW-1:0] eng_idx,
   input  logic [7:0]    eng_wd,
   input  logic [IW-1:0] host_ridx,
   output logic [7:0]    host_rd,
   input  logic [IW-1:0] eng_ridx,
   output logic [7:0]    eng_rd
);
   logic [7:0] mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e] <= '0;
            else if (eng_we && (eng_idx == IW'(e)))
               mem[e] <= eng_wd;
            else if (host_we && (host_idx == IW'(e)))
               mem[e] <= host_wd;
         end
      end
   endgenerate

   assign host_rd = (int'(host_ridx) < DEPTH) ? mem[host_ridx] : 8'h00;
   assign eng_rd  = (int'(eng_ridx)  < DEPTH) ? mem[eng_ridx]  : 8'h00;

endmodule

// File: rtl/lbspi_engine.sv
module lbspi_engine
   import lbspi_pkg::*;
#(
   parameter int unsigned REF_KHZ   = 200000,
   parameter int          BUF_DEPTH = 71,
   parameter int          BUF_BASE  = 128,
   parameter int          MAX_CNT   = BUF_DEPTH - 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sck,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int IW = $clog2(BUF_DEPTH);
   localparam int SW = $clog2(2 * MAX_CNT + 2);

   generate
      if (MAX_CNT > BUF_DEPTH - 3) begin : g_bad_limit
         $error("count limit exceeds usable buffer");
      end
      if (BUF_BASE + BUF_DEPTH > 256) begin : g_bad_window
         $error("buffer window leaves the 8-bit address space");
      end
      if (MAX_CNT > 255) begin : g_bad_count
         $error("count limit does not fit a byte register");
      end
   endgenerate

   logic [7:0]    opcode_q, tx_q, rx_q;
   logic          en_q, err_q, running;
   logic [15:0]   speed_q;
   logic [SW-1:0] byte_idx, next_idx, total, raw_idx;
   logic          wr_ok, in_buf, go, over, next_valid, rx_phase;
   logic [7:0]    sat, next_data, host_rd, eng_rd, rx_byte;
   logic [IW-1:0] host_idx, eng_idx, eng_ridx;
   logic          tick, byte_done, eng_we;

   assign wr_ok    = reg_wr && !running;
   assign in_buf   = (int'(reg_addr) >= BUF_BASE) && (int'(reg_addr) < BUF_BASE + BUF_DEPTH);
   assign host_idx = IW'(reg_addr - 8'(BUF_BASE));
   assign go       = reg_wr && (reg_addr == ADR_CTRL) && reg_wdata[0] && en_q && !running;
   assign over     = reg_wdata > 8'(MAX_CNT);
   assign sat      = over ? 8'(MAX_CNT) : reg_wdata;

   // sequencing of opcode, transmit and receive bytes
   assign total      = SW'(1) + SW'(tx_q) + SW'(rx_q);
   assign next_idx   = running ? byte_idx + SW'(1) : '0;
   assign next_valid = next_idx < total;
   assign eng_ridx   = IW'(next_idx - SW'(1));
   always_comb begin
      if (next_idx == '0)
         next_data = opcode_q;
      else if (next_idx <= SW'(tx_q))
         next_data = eng_rd;
      else
         next_data = 8'h00;
   end

   assign rx_phase = byte_idx > SW'(tx_q);
   assign eng_we   = byte_done && running && rx_phase;
   assign raw_idx  = byte_idx - SW'(1);
   assign eng_idx  = (raw_idx >= SW'(BUF_DEPTH)) ? IW'(raw_idx - SW'(BUF_DEPTH)) : IW'(raw_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         en_q     <= 1'b0;
         speed_q  <= SPEED_RST;
         err_q    <= 1'b0;
         running  <= 1'b0;
         byte_idx <= '0;
      end else begin
         if (wr_ok) begin
            case (reg_addr)
               ADR_OPCODE:   opcode_q       <= reg_wdata;
               ADR_ENABLE:   en_q           <= reg_wdata[0];
               ADR_SPEED_LO: speed_q[7:0]   <= reg_wdata;
               ADR_SPEED_HI: speed_q[15:8]  <= reg_wdata;
               ADR_TXCNT:    tx_q           <= sat;
               ADR_RXCNT:    rx_q           <= sat;
               default: ;
            endcase
         end
         if (wr_ok && ((reg_addr == ADR_TXCNT) || (reg_addr == ADR_RXCNT)) && over)
            err_q <= 1'b1;
         else if (reg_wr && (reg_addr == ADR_STATUS) && reg_wdata[0])
            err_q <= 1'b0;

         if (go) begin
            running  <= 1'b1;
            byte_idx <= '0;
         end else if (byte_done) begin
            byte_idx <= byte_idx + SW'(1);
            if (!next_valid) running <= 1'b0;
         end
      end
   end

   always_comb begin
      if (in_buf)
         reg_rdata = host_rd;
      else begin
         case (reg_addr)
            ADR_OPCODE:   reg_rdata = opcode_q;
            ADR_CTRL:     reg_rdata = {7'd0, running};
            ADR_ENABLE:   reg_rdata = {7'd0, en_q};
            ADR_SPEED_LO: reg_rdata = speed_q[7:0];
            ADR_SPEED_HI: reg_rdata = speed_q[15:8];
            ADR_TXCNT:    reg_rdata = tx_q;
            ADR_RXCNT:    reg_rdata = rx_q;
            ADR_STATUS:   reg_rdata = {7'd0, err_q};
            default:      reg_rdata = 8'h00;
         endcase
      end
   end

   lbspi_clkdiv #(.REF_KHZ(REF_KHZ)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running),
      .code (speed_q[15:12]),
      .tick (tick)
   );

   lbspi_shifter u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go),
      .tick      (tick),
      .miso      (spi_miso),
      .next_data (next_data),
      .next_valid(next_valid),
      .sck       (spi_sck),
      .mosi      (spi_mosi),
      .cs_n      (spi_cs_n),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   lbspi_buf #(.DEPTH(BUF_DEPTH), .IW(IW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_we  (wr_ok && in_buf),
      .host_idx (host_idx),
      .host_wd  (reg_wdata),
      .eng_we   (eng_we),
      .eng_idx  (eng_idx),
      .eng_wd   (rx_byte),
      .host_ridx(host_idx),
      .host_rd  (host_rd),
      .eng_ridx (eng_ridx),
      .eng_rd   (eng_rd)
   );

endmodule

// File: rtl/lbspi_chk.sv
module lbspi_chk
   import lbspi_pkg::*;
#(
   parameter int MAX_CNT = 68
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [7:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       sck,
   input logic       mosi,
   input logic       cs_n,
   input logic       busy,
   input logic       eng_en,
   input logic       err,
   input logic [7:0] tx_cnt,
   input logic [7:0] rx_cnt
);
   // R6
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R6
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));

   // R3
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_cnt) <= MAX_CNT) && (int'(rx_cnt) <= MAX_CNT));

   // R3
   clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && (reg_addr == ADR_TXCNT || reg_addr == ADR_RXCNT)
       && (int'(reg_wdata) > MAX_CNT)) |=> err);

   // R4
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == ADR_CTRL && reg_wdata[0] && eng_en));

   // R4
   no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CTRL && reg_wdata[0] && !eng_en && !busy) |=> !busy);

   // R5
   frame_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);

endmodule

bind lbspi_engine lbspi_chk #(.MAX_CNT(MAX_CNT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .sck      (spi_sck),
   .mosi     (spi_mosi),
   .cs_n     (spi_cs_n),
   .busy     (running),
   .eng_en   (en_q),
   .err      (err_q),
   .tx_cnt   (tx_q),
   .rx_cnt   (rx_q)
);

// File: tb/tb_lbspi_engine.sv
module tb_lbspi_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 71;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_cs_n, spi_mosi;
   logic       spi_miso = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lbspi_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // per-clock compare: SCK must idle low whenever chip select is high (R6)
   always @(negedge clk) begin
      if (rst_n && spi_cs_n) chk("R6", "sck while deselected", int'(spi_sck), 0);
   end

   // ---------------- flash model ----------------
   function automatic logic [7:0] resp(input int k);
      return 8'(k * 29) ^ 8'hA5;
   endfunction

   logic [7:0] cap_q[$];
   logic [7:0] cap_sh;
   logic [7:0] rtmp;
   int  bpos, bidx, rises, hmin, hmax;
   time t_prev;

   task automatic note_edge();
      int d;
      d = int'(($time - t_prev));
      if (d < hmin) hmin = d;
      if (d > hmax) hmax = d;
      t_prev = $time;
   endtask

   always @(negedge spi_cs_n) begin
      bpos = 0;
      bidx = 0;
      rtmp = resp(0);
      spi_miso = rtmp[7];
      t_prev = $time;
   end

   always @(posedge spi_sck) begin
      note_edge();
      cap_sh = {cap_sh[6:0], spi_mosi};
      bpos++;
      rises++;
      if (bpos == 8) begin
         cap_q.push_back(cap_sh);
         bpos = 0;
         bidx++;
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n) begin
         note_edge();
         rtmp = resp(bidx);
         spi_miso = rtmp[7 - bpos];
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic go_wait(output int cyc, output int first_busy);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h02; reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0;
      #1 first_busy = int'(reg_rdata[0]);
      cyc = 0;
      while (reg_rdata[0] && cyc < 60000) begin
         @(negedge clk);
         #1 cyc++;
      end
   endtask

   logic [7:0] model [DEPTH];

   task automatic check_buffer(input string req);
      logic [7:0] v;
      int bad = 0;
      int first = -1;
      for (int i = 0; i < DEPTH; i++) begin
         rd(8'(8'h80 + i), v);
         if (v != model[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(req, $sformatf("buffer mismatches (first idx %0d)", first), bad, 0);
   endtask

   task automatic run_txn(input string tag, input logic [7:0] opc, input int tx, input int rx,
                          input logic [15:0] spd, input int h, input logic [7:0] seed);
      int cyc, fb, errs, nb;
      logic [7:0] d;
      wr(8'h22, spd[7:0]);
      wr(8'h23, spd[15:8]);
      wr(8'h48, 8'(tx));
      wr(8'h4B, 8'(rx));
      wr(8'h00, opc);
      for (int i = 0; i < tx; i++) begin
         d = 8'(seed + i * 3);
         wr(8'(8'h80 + i), d);
         model[i] = d;
      end
      cap_q.delete();
      rises = 0; hmin = 1000000; hmax = 0;
      nb = 1 + tx + rx;
      go_wait(cyc, fb);
      $display("txn %s: %0d cycles", tag, cyc);
      chk("R4", "busy right after start", fb, 1);
      chk("R9", "busy duration", cyc, 16 * nb * h);
      chk("R8", "min half period", hmin, h * CLK_PERIOD);
      chk("R8", "max half period", hmax, h * CLK_PERIOD);
      chk("R5", "sck pulses", rises, 8 * nb);
      chk("R5", "captured bytes", cap_q.size(), nb);
      if (cap_q.size() == nb) begin
         chk("R5", "opcode on mosi", int'(cap_q[0]), int'(opc));
         errs = 0;
         for (int i = 0; i < tx; i++) if (cap_q[1 + i] != 8'(seed + i * 3)) errs++;
         chk("R5", "transmit bytes on mosi", errs, 0);
         errs = 0;
         for (int i = 0; i < rx; i++) if (cap_q[1 + tx + i] != 8'h00) errs++;
         chk("R5", "idle mosi during receive", errs, 0);
      end
      for (int n = 0; n < rx; n++) model[(tx + n) % DEPTH] = resp(1 + tx + n);
      check_buffer("R7");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] v;
      int cyc, fb;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R1", "cs_n in reset", int'(spi_cs_n), 1);
      rst_n = 1'b1;
      rd(8'h00, v); chk("R1", "opcode reset", v, 8'h00);
      rd(8'h02, v); chk("R1", "busy reset", v, 8'h00);
      rd(8'h20, v); chk("R1", "enable reset", v, 8'h00);
      rd(8'h22, v); chk("R1", "speed low reset", v, 8'h33);
      rd(8'h23, v); chk("R1", "speed high reset", v, 8'h33);
      rd(8'h48, v); chk("R1", "tx count reset", v, 8'h00);
      rd(8'h4B, v); chk("R1", "rx count reset", v, 8'h00);
      rd(8'h4C, v); chk("R1", "status reset", v, 8'h00);
      chk("R1", "cs_n after reset", int'(spi_cs_n), 1);
      chk("R1", "sck after reset", int'(spi_sck), 0);

      // R2 readback
      wr(8'h00, 8'h5A); rd(8'h00, v); chk("R2", "opcode readback", v, 8'h5A);
      wr(8'h22, 8'hC1); rd(8'h22, v); chk("R2", "speed low readback", v, 8'hC1);
      wr(8'h23, 8'h4E); rd(8'h23, v); chk("R2", "speed high readback", v, 8'h4E);
      wr(8'h48, 8'd44); rd(8'h48, v); chk("R2", "tx count readback", v, 8'd44);
      wr(8'h4B, 8'd68); rd(8'h4B, v); chk("R2", "rx count at limit", v, 8'd68);
      rd(8'h4C, v); chk("R3", "no flag at limit", v, 8'h00);

      // R11 buffer window edges
      wr(8'h80, 8'h11); model[0] = 8'h11;
      wr(8'hC6, 8'h99); model[70] = 8'h99;
      rd(8'h80, v); chk("R11", "buffer first byte", v, 8'h11);
      rd(8'hC6, v); chk("R11", "buffer last byte", v, 8'h99);

      // R3 clamp and sticky flag
      wr(8'h48, 8'd80); rd(8'h48, v); chk("R3", "tx clamp", v, 8'd68);
      rd(8'h4C, v); chk("R3", "flag set", v, 8'h01);
      wr(8'h48, 8'd3); rd(8'h4C, v); chk("R3", "flag sticky", v, 8'h01);
      wr(8'h4C, 8'h01); rd(8'h4C, v); chk("R3", "flag cleared", v, 8'h00);
      wr(8'h4B, 8'hFF); rd(8'h4B, v); chk("R3", "rx clamp", v, 8'd68);
      wr(8'h4C, 8'h01);

      // R4 start ignored while disabled
      wr(8'h02, 8'h01);
      rd(8'h02, v); chk("R4", "no start when disabled", v, 8'h00);
      chk("R4", "cs_n stays high when disabled", int'(spi_cs_n), 1);

      wr(8'h20, 8'h01); rd(8'h20, v); chk("R2", "enable readback", v, 8'h01);

      run_txn("fast read id", 8'h9F, 0, 3, 16'h4000, 1, 8'h00);
      run_txn("read 33M", 8'h03, 4, 5, 16'h1000, 4, 8'h20);
      run_txn("full wrap 66M", 8'h0B, 68, 68, 16'h0000, 2, 8'h40);
      run_txn("reserved 5", 8'h06, 1, 0, 16'h5000, 125, 8'h7C);
      run_txn("other fields", 8'h05, 2, 2, 16'h3F0A, 7, 8'h31);
      run_txn("code 12", 8'hAB, 0, 1, 16'hC000, 125, 8'h00);

      // R10 writes during a command are ignored
      wr(8'h22, 8'h00); wr(8'h23, 8'h70);
      wr(8'h48, 8'd0); wr(8'h4B, 8'd0); wr(8'h00, 8'hC7);
      cap_q.delete(); rises = 0;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h02; reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0;
      wr(8'h00, 8'hEE);
      wr(8'h48, 8'd5);
      wr(8'h80, 8'h77);
      wr(8'h23, 8'h00);
      wr(8'h20, 8'h00);
      rd(8'h02, v); chk("R10", "still busy during writes", v, 8'h01);
      cyc = 0;
      while (reg_rdata[0] && cyc < 60000) begin
         @(negedge clk);
         #1 cyc++;
      end
      rd(8'h00, v); chk("R10", "opcode kept", v, 8'hC7);
      rd(8'h48, v); chk("R10", "tx count kept", v, 8'd0);
      rd(8'h23, v); chk("R10", "speed kept", v, 8'h70);
      rd(8'h20, v); chk("R10", "enable kept", v, 8'h01);
      rd(8'h80, v); chk("R10", "buffer kept", v, int'(model[0]));
      chk("R10", "frame length", cap_q.size(), 1);
      if (cap_q.size() == 1) chk("R10", "frame opcode", int'(cap_q[0]), 8'hC7);

      // R4 a second start after completion works
      go_wait(cyc, fb);
      chk("R4", "restart busy", fb, 1);
      chk("R9", "restart duration", cyc, 16 * 125);

      summary();
      $finish;
   end

endmodule